// File: doc/BRIEF.md
# PCI Host Configuration Decoder

This block is the front end of a PCI host bridge. A CPU-side request port delivers single-beat accesses. Requests that fall in a fixed 256 MB configuration window are claimed. The block splits the window offset into bus, device, function and register fields, and drives the select line of the one device slot registered at that position. The selected device supplies read data. The block registers that data and returns it with a response one cycle after the request. Unclaimed addresses get no response and are left to other targets.

A build parameter sets how many offset bits belong to each function. At 16, the decoder uses the older dense layout. At 12, it uses the extended-mapping layout. The device table is also a parameter. Each entry holds a bus/device/function position and the interrupt pin the device drives.

Two other functions are fully combinational. Three translators turn PCI-side I/O, memory and DMA addresses into physical addresses by adding a fixed base. An interrupt router forwards the level on each slot's own pin to the host line named by that device's interrupt-line register.

Top module: `pci_cfg_host`

## Requirements
- R1: `req_claim` is high in the same cycle exactly when `req_valid` is high and `req_addr` lies in [0x3000_0000, 0x3FFF_FFFF]. No other address is claimed.
- R2: With `DEV_BITS`=16, the function number is taken from address bits [18:16], the device number from [23:19] and the bus number from [27:24].
- R3: With `DEV_BITS`=12, the function number is taken from address bits [14:12], the device number from [19:15] and the bus number from [27:20].
- R4: During a claimed access, bit s of `cfg_sel` is high exactly when slot s's table position equals the decoded fields. At most one bit is ever high. Slot s's position occupies bits [16s+15:16s] of `SLOT_BDF` as {bus[7:0], device[4:0], function[2:0]}.
- R5: An access whose decoded bus number is not zero selects no slot, even if a table entry names that bus.
- R6: While an access is claimed, `cfg_reg` equals address bits [DEV_BITS-1:0], `cfg_we` equals `req_write`, and `cfg_wdata` and `cfg_be` equal `req_wdata` and `req_be`.
- R7: `rsp_valid` is high in the cycle after each claimed request and low in the cycle after any cycle without a claim.
- R8: The response data of a read that selected slot s is that slot's `cfg_rdata` word, at bits [32s+31:32s]. A read that selected no slot returns 0xFFFF_FFFF. A write returns 0.
- R9: A claimed write that selects no slot drives no select line, so no device state changes, and it still receives its response.
- R10: Each of `pio_phys_addr`, `mem_phys_addr` and `dma_phys_addr` equals its PCI-side input plus `PIO_BASE`, `MEM_BASE` or `DMA_BASE` respectively, modulo 2^ADDR_W, in the same cycle.
- R11: `host_irq[k]` is high exactly when some slot whose `dev_int_line` byte equals k has its own pin high. Slot s owns pins [3s+2:3s] in the order INTA, INTB, INTC. Its pin is selected by `SLOT_PIN[2s+1:2s]` (0 = INTA, 1 = INTB, 2 = INTC). The slot's other pins, and line numbers of `NUM_LINES` or more, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | CPU request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Physical request address |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte enables |
| req_claim | output | 1 | Address lies in the configuration window |
| rsp_valid | output | 1 | Response for the previous cycle's claimed request |
| rsp_rdata | output | 32 | Response read data |
| cfg_sel | output | NUM_SLOTS | One-hot device slot select |
| cfg_we | output | 1 | Write strobe to the selected device |
| cfg_reg | output | DEV_BITS | Register offset inside the function |
| cfg_wdata | output | 32 | Write data to devices |
| cfg_be | output | 4 | Byte enables to devices |
| cfg_rdata | input | NUM_SLOTS*32 | Read data from each slot |
| dev_irq | input | NUM_SLOTS*3 | Interrupt pins INTA..INTC of each slot |
| dev_int_line | input | NUM_SLOTS*8 | Interrupt-line register value of each slot |
| host_irq | output | NUM_LINES | Host interrupt lines |
| pio_pci_addr | input | ADDR_W | PCI I/O-space address |
| pio_phys_addr | output | ADDR_W | Translated I/O address |
| mem_pci_addr | input | ADDR_W | PCI memory-space address |
| mem_phys_addr | output | ADDR_W | Translated memory address |
| dma_pci_addr | input | ADDR_W | Device DMA address on the PCI bus |
| dma_phys_addr | output | ADDR_W | Translated DMA address |

## Verification
A configuration access and interrupt routing can happen in the same cycle. The bench changes the interrupt pins and line registers just before each access, so both happen in the same cycle. It then checks `host_irq` together with the select lines and the response.

One request address is also decoded by both layouts in the same cycle. A single address can hit one slot under the 16-bit layout and miss, or hit a different slot, under the 12-bit layout. The bench therefore drives two instances with identical requests and judges each against its own field positions.

// File: rtl/pci_cfg_pkg.sv
package pci_cfg_pkg;
  localparam int unsigned OFF_W = 28;  // 256 MB window

  typedef struct packed {
    logic [7:0] bus;
    logic [4:0] dev;
    logic [2:0] func;
  } bdf_t;

  typedef enum logic [1:0] {
    PIN_A = 2'd0,
    PIN_B = 2'd1,
    PIN_C = 2'd2
  } irq_pin_e;

  // Split a window offset into its position fields.
  function automatic bdf_t split_offset(input logic [OFF_W-1:0] off,
                                        input int unsigned dev_bits);
    logic [OFF_W-1:0] sh;
    bdf_t r;
    sh     = off >> dev_bits;
    r.func = sh[2:0];
    r.dev  = sh[7:3];
    r.bus  = sh[15:8];
    return r;
  endfunction

  // Base-plus-address translation, wide enough for any address width.
  function automatic logic [63:0] add_base(input logic [63:0] base,
                                           input logic [63:0] addr);
    return base + addr;
  endfunction
endpackage

// File: rtl/pci_cfg_decode.sv
module pci_cfg_decode
  import pci_cfg_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] CFG_BASE = 32'h3000_0000,
  parameter int unsigned DEV_BITS  = 16,
  parameter int unsigned NUM_SLOTS = 4,
  parameter logic [NUM_SLOTS*16-1:0] SLOT_BDF = '0
) (
  input  logic                 req_valid,
  input  logic [ADDR_W-1:0]    req_addr,
  output logic                 claim,
  output logic [NUM_SLOTS-1:0] sel,
  output logic [DEV_BITS-1:0]  reg_off
);
  bdf_t pos;
  logic in_win;

  assign in_win  = (req_addr[ADDR_W-1:OFF_W] == CFG_BASE[ADDR_W-1:OFF_W]);
  assign claim   = req_valid && in_win;
  assign pos     = split_offset(req_addr[OFF_W-1:0], DEV_BITS);
  assign reg_off = req_addr[DEV_BITS-1:0];

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    localparam bdf_t ENTRY = SLOT_BDF[s*16 +: 16];
    assign sel[s] = claim && (pos.bus == 8'd0) && (pos == ENTRY);
  end
endmodule

// File: rtl/pci_irq_router.sv
module pci_irq_router
  import pci_cfg_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 4,
  parameter int unsigned NUM_LINES = 16,
  parameter logic [NUM_SLOTS*2-1:0] SLOT_PIN = '0
) (
  input  logic [NUM_SLOTS*3-1:0] dev_irq,
  input  logic [NUM_SLOTS*8-1:0] dev_int_line,
  output logic [NUM_LINES-1:0]   host_irq
);
  logic [NUM_SLOTS-1:0] lvl;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_pin
    localparam int unsigned PIN = int'(SLOT_PIN[s*2 +: 2]);
    if (PIN <= int'(PIN_C)) begin : g_ok
      assign lvl[s] = dev_irq[s*3 + PIN];
    end else begin : g_none
      assign lvl[s] = 1'b0;
    end
  end

  always_comb begin
    host_irq = '0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      for (int k = 0; k < NUM_LINES; k++) begin
        if (dev_int_line[s*8 +: 8] == 8'(k)) host_irq[k] = host_irq[k] | lvl[s];
      end
    end
  end
endmodule

// File: rtl/pci_addr_xlate.sv
module pci_addr_xlate
  import pci_cfg_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE = '0
) (
  input  logic [ADDR_W-1:0] pci_addr,
  output logic [ADDR_W-1:0] phys_addr
);
  assign phys_addr = ADDR_W'(add_base(64'(BASE), 64'(pci_addr)));
endmodule

// File: rtl/pci_cfg_host.sv
module pci_cfg_host
  import pci_cfg_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] CFG_BASE = 32'h3000_0000,
  parameter int unsigned DEV_BITS  = 16,
  parameter int unsigned NUM_SLOTS = 4,
  parameter int unsigned NUM_LINES = 16,
  parameter logic [NUM_SLOTS*16-1:0] SLOT_BDF = 64'h0110_000B_0008_0000,
  parameter logic [NUM_SLOTS*2-1:0]  SLOT_PIN = 8'h24,
  parameter logic [ADDR_W-1:0] PIO_BASE = 32'h2F00_0000,
  parameter logic [ADDR_W-1:0] MEM_BASE = 32'h4000_0000,
  parameter logic [ADDR_W-1:0] DMA_BASE = 32'h8000_0000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic                   req_write,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [31:0]            req_wdata,
  input  logic [3:0]             req_be,
  output logic                   req_claim,
  output logic                   rsp_valid,
  output logic [31:0]            rsp_rdata,
  output logic [NUM_SLOTS-1:0]   cfg_sel,
  output logic                   cfg_we,
  output logic [DEV_BITS-1:0]    cfg_reg,
  output logic [31:0]            cfg_wdata,
  output logic [3:0]             cfg_be,
  input  logic [NUM_SLOTS*32-1:0] cfg_rdata,
  input  logic [NUM_SLOTS*3-1:0] dev_irq,
  input  logic [NUM_SLOTS*8-1:0] dev_int_line,
  output logic [NUM_LINES-1:0]   host_irq,
  input  logic [ADDR_W-1:0]      pio_pci_addr,
  output logic [ADDR_W-1:0]      pio_phys_addr,
  input  logic [ADDR_W-1:0]      mem_pci_addr,
  output logic [ADDR_W-1:0]      mem_phys_addr,
  input  logic [ADDR_W-1:0]      dma_pci_addr,
  output logic [ADDR_W-1:0]      dma_phys_addr
);
  localparam int unsigned NXL = 3;
  localparam logic [NXL*ADDR_W-1:0] XL_BASES = {DMA_BASE, MEM_BASE, PIO_BASE};

  // Named internal events, visible to the bound checker.
  logic        acc_hit;
  logic [31:0] sel_rdata;
  logic [31:0] next_rdata;
  logic [NXL*ADDR_W-1:0] xl_in, xl_out;

  pci_cfg_decode #(
    .ADDR_W(ADDR_W), .CFG_BASE(CFG_BASE), .DEV_BITS(DEV_BITS),
    .NUM_SLOTS(NUM_SLOTS), .SLOT_BDF(SLOT_BDF)
  ) u_decode (
    .req_valid(req_valid), .req_addr(req_addr),
    .claim(req_claim), .sel(cfg_sel), .reg_off(cfg_reg)
  );

  assign acc_hit   = |cfg_sel;
  assign cfg_we    = req_write;
  assign cfg_wdata = req_wdata;
  assign cfg_be    = req_be;

  always_comb begin
    sel_rdata = '0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (cfg_sel[s]) sel_rdata = sel_rdata | cfg_rdata[s*32 +: 32];
    end
  end

  assign next_rdata = req_write ? 32'h0 : (acc_hit ? sel_rdata : 32'hFFFF_FFFF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_claim;
      if (req_claim) rsp_rdata <= next_rdata;
    end
  end

  pci_irq_router #(
    .NUM_SLOTS(NUM_SLOTS), .NUM_LINES(NUM_LINES), .SLOT_PIN(SLOT_PIN)
  ) u_irq (
    .dev_irq(dev_irq), .dev_int_line(dev_int_line), .host_irq(host_irq)
  );

  assign xl_in = {dma_pci_addr, mem_pci_addr, pio_pci_addr};
  for (genvar x = 0; x < NXL; x++) begin : g_xl
    pci_addr_xlate #(
      .ADDR_W(ADDR_W), .BASE(XL_BASES[x*ADDR_W +: ADDR_W])
    ) u_xl (
      .pci_addr(xl_in[x*ADDR_W +: ADDR_W]), .phys_addr(xl_out[x*ADDR_W +: ADDR_W])
    );
  end
  assign pio_phys_addr = xl_out[0*ADDR_W +: ADDR_W];
  assign mem_phys_addr = xl_out[1*ADDR_W +: ADDR_W];
  assign dma_phys_addr = xl_out[2*ADDR_W +: ADDR_W];
endmodule

// File: rtl/pci_cfg_host_chk.sv
module pci_cfg_host_chk #(
  parameter int unsigned ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] CFG_BASE = 32'h3000_0000,
  parameter int unsigned DEV_BITS  = 16,
  parameter int unsigned NUM_SLOTS = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic                 req_write,
  input logic [ADDR_W-1:0]    req_addr,
  input logic                 req_claim,
  input logic                 rsp_valid,
  input logic [31:0]          rsp_rdata,
  input logic [NUM_SLOTS-1:0] cfg_sel,
  input logic                 acc_hit
);
  logic in_window;
  logic bus_zero;
  assign in_window = (req_addr >= CFG_BASE) && (req_addr - CFG_BASE < ADDR_W'(32'h1000_0000));
  assign bus_zero  = ((req_addr[27:0] >> (DEV_BITS + 8)) == 28'd0);

  p_claim_window_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_claim |-> (req_valid && in_window));

  p_sel_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cfg_sel));

  p_sel_needs_claim_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|cfg_sel) |-> req_claim);

  p_sel_bus_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|cfg_sel) |-> bus_zero);

  p_rsp_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_claim |=> rsp_valid);

  p_no_stray_rsp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !req_claim |=> !rsp_valid);

  p_miss_ones_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_claim && !req_write && !acc_hit) |=> (rsp_rdata == 32'hFFFF_FFFF));

  p_write_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_claim && req_write) |=> (rsp_rdata == 32'h0));
endmodule

bind pci_cfg_host pci_cfg_host_chk #(
  .ADDR_W(ADDR_W), .CFG_BASE(CFG_BASE), .DEV_BITS(DEV_BITS), .NUM_SLOTS(NUM_SLOTS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .req_claim(req_claim), .rsp_valid(rsp_valid),
  .rsp_rdata(rsp_rdata), .cfg_sel(cfg_sel), .acc_hit(acc_hit)
);

// File: tb/pci_cfg_host_bench.sv
module pci_cfg_host_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic        req_valid = 0, req_write = 0;
  logic [31:0] req_addr = 0, req_wdata = 0;
  logic [3:0]  req_be = 0;
  logic [11:0] dev_irq = 0;
  logic [31:0] dev_int_line = 0;
  logic [31:0] pio_in = 0, mem_in = 0, dma_in = 0;

  logic        claim_a, claim_b, rv_a, rv_b, we_a, we_b;
  logic [31:0] rd_a, rd_b, wd_a, wd_b;
  logic [3:0]  sel_a, sel_b, be_a, be_b;
  logic [15:0] reg_a;
  logic [11:0] reg_b;
  logic [127:0] crd_a, crd_b;
  logic [15:0] irq_a, irq_b;
  logic [31:0] pio_a, mem_a, dma_a, pio_b, mem_b, dma_b;

  // Device models: each slot answers with its number and the register offset.
  always_comb begin
    for (int s = 0; s < 4; s++) begin
      crd_a[s*32 +: 32] = {8'hD0, 4'(s), 4'h0, reg_a};
      crd_b[s*32 +: 32] = {8'hD0, 4'(s), 8'h00, reg_b};
    end
  end

  pci_cfg_host u_pci_cfg_host (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .req_claim(claim_a), .rsp_valid(rv_a), .rsp_rdata(rd_a),
    .cfg_sel(sel_a), .cfg_we(we_a), .cfg_reg(reg_a), .cfg_wdata(wd_a), .cfg_be(be_a),
    .cfg_rdata(crd_a), .dev_irq(dev_irq), .dev_int_line(dev_int_line), .host_irq(irq_a),
    .pio_pci_addr(pio_in), .pio_phys_addr(pio_a), .mem_pci_addr(mem_in),
    .mem_phys_addr(mem_a), .dma_pci_addr(dma_in), .dma_phys_addr(dma_a)
  );

  pci_cfg_host #(.DEV_BITS(12)) u_pci_cfg_host_ecam (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .req_claim(claim_b), .rsp_valid(rv_b), .rsp_rdata(rd_b),
    .cfg_sel(sel_b), .cfg_we(we_b), .cfg_reg(reg_b), .cfg_wdata(wd_b), .cfg_be(be_b),
    .cfg_rdata(crd_b), .dev_irq(dev_irq), .dev_int_line(dev_int_line), .host_irq(irq_b),
    .pio_pci_addr(pio_in), .pio_phys_addr(pio_b), .mem_pci_addr(mem_in),
    .mem_phys_addr(mem_b), .dma_pci_addr(dma_in), .dma_phys_addr(dma_b)
  );

  // Device table as the requirements lay it out.
  int unsigned T_BUS [4] = '{0, 0, 0, 1};
  int unsigned T_DEV [4] = '{0, 1, 1, 2};
  int unsigned T_FN  [4] = '{0, 0, 3, 0};
  int unsigned T_PIN [4] = '{0, 1, 2, 0};

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int exp_slot(input logic [31:0] a, input bit legacy);
    int unsigned bus, dev, fn;
    if (legacy) begin
      fn = a[18:16]; dev = a[23:19]; bus = a[27:24];
    end else begin
      fn = a[14:12]; dev = a[19:15]; bus = a[27:20];
    end
    if (a[31:28] != 4'h3 || bus != 0) return -1;
    for (int s = 0; s < 4; s++)
      if (T_BUS[s] == 0 && T_DEV[s] == dev && T_FN[s] == fn) return s;
    return -1;
  endfunction

  function automatic logic [15:0] exp_irq(input logic [11:0] pins, input logic [31:0] lines);
    logic [15:0] r = '0;
    for (int s = 0; s < 4; s++) begin
      int unsigned ln = lines[s*8 +: 8];
      if (ln < 16 && pins[s*3 + T_PIN[s]]) r[ln] = 1'b1;
    end
    return r;
  endfunction

  function automatic logic [31:0] exp_rd(input int s, input bit wr, input logic [31:0] a,
                                         input bit legacy);
    if (wr) return 32'h0;
    if (s < 0) return 32'hFFFF_FFFF;
    return legacy ? {8'hD0, 4'(s), 4'h0, a[15:0]} : {8'hD0, 4'(s), 8'h00, a[11:0]};
  endfunction

  task automatic access(input bit wr, input logic [31:0] a, input logic [31:0] wd,
                        input logic [3:0] be, input string tag_a, input string tag_b);
    bit in_win;
    int sa, sb;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = wd; req_be = be;
    #2;
    in_win = (a[31:28] == 4'h3);
    sa = exp_slot(a, 1'b1);
    sb = exp_slot(a, 1'b0);
    chk(claim_a == in_win, "R1 claim legacy", 32'(claim_a), 32'(in_win));
    chk(claim_b == in_win, "R1 claim ecam", 32'(claim_b), 32'(in_win));
    chk(sel_a == ((sa >= 0) ? 4'(1 << sa) : 4'h0), tag_a, 32'(sel_a),
        32'((sa >= 0) ? (1 << sa) : 0));
    chk(sel_b == ((sb >= 0) ? 4'(1 << sb) : 4'h0), tag_b, 32'(sel_b),
        32'((sb >= 0) ? (1 << sb) : 0));
    if (in_win) begin
      chk(reg_a == a[15:0] && we_a == wr && be_a == be && wd_a == wd,
          "R6 passthrough legacy", 32'(reg_a), 32'(a[15:0]));
      chk(reg_b == a[11:0] && we_b == wr && be_b == be && wd_b == wd,
          "R6 passthrough ecam", 32'(reg_b), 32'(a[11:0]));
    end
    chk(irq_a == exp_irq(dev_irq, dev_int_line) && irq_b == irq_a,
        "R11 irq during access", 32'(irq_a), 32'(exp_irq(dev_irq, dev_int_line)));
    @(negedge clk);
    req_valid = 0;
    chk(rv_a == in_win && rv_b == in_win, "R7 response", 32'({rv_a, rv_b}),
        32'({in_win, in_win}));
    if (in_win) begin
      chk(rd_a == exp_rd(sa, wr, a, 1'b1), "R8 rdata legacy", rd_a, exp_rd(sa, wr, a, 1'b1));
      chk(rd_b == exp_rd(sb, wr, a, 1'b0), "R8 rdata ecam", rd_b, exp_rd(sb, wr, a, 1'b0));
    end
  endtask

  task automatic check_xlate;
    #2;
    chk(pio_a == pio_in + 32'h2F00_0000 && pio_b == pio_a, "R10 pio", pio_a, pio_in + 32'h2F00_0000);
    chk(mem_a == mem_in + 32'h4000_0000 && mem_b == mem_a, "R10 mem", mem_a, mem_in + 32'h4000_0000);
    chk(dma_a == dma_in + 32'h8000_0000 && dma_b == dma_a, "R10 dma", dma_a, dma_in + 32'h8000_0000);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // Reset state
    chk(rv_a == 0 && rd_a == 0 && rv_b == 0 && rd_b == 0, "R7 reset", rd_a, 32'h0);
    chk(sel_a == 0 && sel_b == 0 && irq_a == 0, "R4 reset idle", 32'(sel_a), 32'h0);

    // Directed: slot hits in each layout
    access(0, 32'h3008_0010, 0, 4'hF, "R2 slot1", "R3 legacy addr");
    access(0, 32'h300B_003C, 0, 4'hF, "R2 slot2", "R3 legacy addr");
    access(0, 32'h3000_B004, 0, 4'hF, "R2 ecam addr", "R3 slot2");
    access(1, 32'h3000_8020, 32'hCAFE_0001, 4'h3, "R2 write", "R3 write slot1");
    // Nonzero bus, table entry exists there
    access(0, 32'h3110_0000, 0, 4'hF, "R5 bus1 legacy", "R5 bus1 ecam");
    access(0, 32'h3020_0000, 0, 4'hF, "R5 ecam bus2", "R5 ecam bus2");
    // Writes to empty positions
    access(1, 32'h3078_0000, 32'h1234_5678, 4'hF, "R9 write miss", "R9 write miss");
    // Window edges
    access(0, 32'h2FFF_FFFC, 0, 4'hF, "R1 below", "R1 below");
    access(0, 32'h4000_0000, 0, 4'hF, "R1 above", "R1 above");
    access(0, 32'h3FFF_FFFC, 0, 4'hF, "R1 top edge", "R1 top edge");

    // Interrupt routing: wrong pin, shared line, out-of-range line
    dev_int_line = {8'd15, 8'd9, 8'd5, 8'd5};
    dev_irq = 12'b000_000_000_110;  // slot0 other pins only
    #2 chk(irq_a == 16'h0, "R11 other pin ignored", 32'(irq_a), 32'h0);
    dev_irq = 12'b001_100_010_000;  // slot1 B, slot2 C, slot3 A
    #2 chk(irq_a == exp_irq(dev_irq, dev_int_line), "R11 routed", 32'(irq_a),
           32'(exp_irq(dev_irq, dev_int_line)));
    dev_int_line = {8'd15, 8'd20, 8'd5, 8'd5};
    #2 chk(irq_a == exp_irq(dev_irq, dev_int_line), "R11 line out of range", 32'(irq_a),
           32'(exp_irq(dev_irq, dev_int_line)));

    // Translation corners
    pio_in = 32'hFFFF_FFFF; mem_in = 32'h0; dma_in = 32'h8000_0000;
    check_xlate();

    // Random mix
    for (int i = 0; i < 400; i++) begin
      logic [31:0] a;
      int unsigned s = $urandom % 4;
      int unsigned kind = $urandom % 4;
      logic [15:0] r = 16'($urandom) & 16'hFFFC;
      case (kind)
        0: a = $urandom;
        1: a = 32'h3000_0000 | ($urandom & 32'h0FFF_FFFC);
        2: a = 32'h3000_0000 | (T_DEV[s] << 19) | (T_FN[s] << 16) | 32'(r);
        default: a = 32'h3000_0000 | (T_DEV[s] << 15) | (T_FN[s] << 12) | 32'(r[11:0]);
      endcase
      dev_irq = 12'($urandom);
      for (int k = 0; k < 4; k++) dev_int_line[k*8 +: 8] = 8'($urandom % 20);
      pio_in = $urandom; mem_in = $urandom; dma_in = $urandom;
      check_xlate();
      access(bit'($urandom), a, $urandom, 4'($urandom), "R2 R4 random", "R3 R4 random");
    end
    finish_run();
  end
endmodule